// File: doc/BRIEF.md
# ECC Message Object Store

This block is the message-object memory of a CAN-style controller. It keeps a fixed number of objects, each a wide data word. Every object has its own check word, held in a storage array apart from the data. While protection is on, a write derives the check word from the data with an extended Hamming code: eight position parities plus one parity over the whole codeword. A read recomputes the code, repairs a lone flipped bit when correction is allowed, and reports what it found. The report goes to sticky status flags, two object-number capture registers, an interrupt line, and the object's valid bit, which the block clears when the data cannot be trusted.

The host reaches the array through a request channel and a response channel, both valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while an initialization sweep runs and while a read is in flight or its response is waiting. A response stays on `rsp_valid`/`rsp_data`, unchanged, until the host raises `rsp_ready`. A diagnostic mode lets the host write data and check words separately while protection is off, so that faults can be planted on purpose. An initialization sweep zeroes every object.

Top module: `ecc_msg_store`

## Requirements
- R1: With protection on, a write stores the data together with a generated check word. A read of an unaltered object returns the written data and sets no flag. `rsp_valid` rises on the second rising edge after the read is accepted.
- R2: One flipped data bit, with `corr_off` low, returns corrected data. It sets the single-error flag and loads `sec_obj` with the object number. It sets no parity-error flag and leaves the valid bit set.
- R3: One flipped data bit, with `corr_off` high, returns the uncorrected data. It sets the single-error flag and the parity-error flag, loads `sec_obj`, and clears the object's valid bit.
- R4: Two flipped bits return the raw data. They set the double-error flag and the parity-error flag, load `ded_obj`, and clear the valid bit.
- R5: Check-word bit 8 is the overall parity and bits 7:0 are the position parities. A zero syndrome with an overall mismatch counts as a single error and leaves the data as stored. A nonzero syndrome with the overall parity matching counts as a double error.
- R6: With protection off, a read does no checking and sets no flag. A normal write stores data only and leaves the stored check word untouched.
- R7: With `diag_en` high and protection off, `req_wmask[0]` enables the data write and `req_wmask[1]` writes `req_wchk` as the check word. A read accepted with `diag_en` high copies its single-error and double-error results into `diag_single`/`diag_double`. With `diag_en` low, these two flags stay clear.
- R8: A pulse on `init_start` writes zero data into all objects, one per cycle, for `NUM_OBJ` cycles. It writes generated check words only when protection is on, runs no check, clears every valid bit, and holds `req_ready` low for its whole length.
- R9: All five flags stay set until cleared through `flag_clr`: bit0 single, bit1 double, bit2 parity, bit3 diagnostic single, bit4 diagnostic double. A set in the same cycle as a clear wins.
- R10: `irq` is high exactly when the parity-error flag is set and `irq_en` is high.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response and its data hold steady and no new request is accepted.
- R12: Valid bits are zero after reset. A write that stores data sets the object's valid bit to `req_wvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_en | input | 1 | Protection enable: generate and check code words |
| corr_off | input | 1 | Disables single-bit correction when high |
| diag_en | input | 1 | Diagnostic mode enable |
| irq_en | input | 1 | Error interrupt enable |
| init_start | input | 1 | Starts the initialization sweep |
| init_busy | output | 1 | Initialization sweep running |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Object number |
| req_wdata | input | DATA_W | Write data |
| req_wchk | input | DATA_W check width (9) | Check word for diagnostic writes |
| req_wmask | input | 2 | Diagnostic write select: bit0 data, bit1 check word |
| req_wvalid | input | 1 | Valid bit value stored with a data write |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes response |
| rsp_data | output | DATA_W | Read data |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| err_single | output | 1 | Single-error flag |
| err_double | output | 1 | Double-error flag |
| err_parity | output | 1 | Parity-error flag |
| diag_single | output | 1 | Diagnostic single-error flag |
| diag_double | output | 1 | Diagnostic double-error flag |
| irq | output | 1 | Error interrupt |
| sec_obj | output | AW | Last object with a single error |
| ded_obj | output | AW | Last object with a double error |
| obj_valid | output | NUM_OBJ | Per-object valid bits |

## Verification
A write lands on the rising edge that accepts it. The read accepted on that edge captures the raw word. The response data, the flags, both capture registers and any valid-bit clear all appear together two rising edges after acceptance, and `irq` follows the flags with no delay. The bench drives and samples on falling edges. It waits exactly two rising edges after an accepted read before it looks at the response and the status. It counts sweep length by falling edges with `init_busy` high. A held response is checked on several falling edges before the host accepts it.

// File: rtl/ecc_msg_pkg.sv
package ecc_msg_pkg;

  // Number of position parities for a data width (extended code adds one).
  function automatic int unsigned parity_bits(int unsigned dw);
    int unsigned r;
    r = 0;
    for (int unsigned t = 1; t < 16; t++)
      if (r == 0 && (32'd1 << t) >= dw + t + 1) r = t;
    return r;
  endfunction

  // Codeword position (1-based, skipping powers of two) of data bit idx.
  function automatic int unsigned cw_pos(int unsigned idx);
    int unsigned res;
    int unsigned n;
    res = 0;
    n   = 0;
    for (int unsigned q = 1; q < 2048; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == idx && res == 0) res = q;
        n++;
      end
    end
    return res;
  endfunction

  // flag_clr bit positions
  localparam int CLR_SINGLE  = 0;
  localparam int CLR_DOUBLE  = 1;
  localparam int CLR_PARITY  = 2;
  localparam int CLR_DSINGLE = 3;
  localparam int CLR_DDOUBLE = 4;
  localparam int CLR_W       = 5;

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_msg_pkg::*;
#(
  parameter int DW = 136,
  parameter int PW = parity_bits(DW)
) (
  input  logic [DW-1:0] data,
  output logic [PW:0]   chk
);

  logic [PW-1:0] pos_tab [DW];
  logic [PW-1:0] par;

  for (genvar i = 0; i < DW; i++) begin : g_pos
    localparam int unsigned P = cw_pos(i);
    assign pos_tab[i] = PW'(P);
  end

  // XOR of the positions of all set data bits gives every position parity.
  always_comb begin
    par = '0;
    for (int i = 0; i < DW; i++)
      par = par ^ (pos_tab[i] & {PW{data[i]}});
  end

  assign chk = {(^data) ^ (^par), par};

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_msg_pkg::*;
#(
  parameter int DW = 136,
  parameter int PW = parity_bits(DW)
) (
  input  logic [DW-1:0] data,
  input  logic [PW:0]   chk,
  output logic [DW-1:0] fixed,
  output logic          single,
  output logic          double
);

  logic [PW:0]   recomp;
  logic [PW-1:0] syn;
  logic          ov_mis;

  ecc_encoder #(.DW(DW), .PW(PW)) u_reenc (
    .data (data),
    .chk  (recomp)
  );

  assign syn    = chk[PW-1:0] ^ recomp[PW-1:0];
  assign ov_mis = ^{data, chk};
  assign single = ov_mis;
  assign double = !ov_mis && (syn != '0);

  for (genvar i = 0; i < DW; i++) begin : g_fix
    localparam int unsigned P = cw_pos(i);
    assign fixed[i] = data[i] ^ (ov_mis && (syn == PW'(P)));
  end

endmodule

// File: rtl/msg_mem.sv
module msg_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 136,
  parameter int CW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_data_en,
  input  logic          wr_chk_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] wchk,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] rchk
);

  logic [DW-1:0] data_arr [DEPTH];
  logic [CW-1:0] chk_arr  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_data_en) data_arr[waddr] <= wdata;
    if (wr_chk_en)  chk_arr[waddr]  <= wchk;
    if (rd_en) begin
      rdata <= data_arr[raddr];
      rchk  <= chk_arr[raddr];
    end
  end

endmodule

// File: rtl/ecc_msg_store.sv
module ecc_msg_store
  import ecc_msg_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int DATA_W  = 136,
  localparam int AW     = $clog2(NUM_OBJ),
  localparam int PW     = parity_bits(DATA_W),
  localparam int CW     = PW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prot_en,
  input  logic               corr_off,
  input  logic               diag_en,
  input  logic               irq_en,
  input  logic               init_start,
  output logic               init_busy,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [CW-1:0]      req_wchk,
  input  logic [1:0]         req_wmask,
  input  logic               req_wvalid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [CLR_W-1:0]   flag_clr,
  output logic               err_single,
  output logic               err_double,
  output logic               err_parity,
  output logic               diag_single,
  output logic               diag_double,
  output logic               irq,
  output logic [AW-1:0]      sec_obj,
  output logic [AW-1:0]      ded_obj,
  output logic [NUM_OBJ-1:0] obj_valid
);

  // ---------------- request side ----------------
  logic              accept, host_wr, rd_en, diag_wr;
  logic [AW-1:0]     init_idx;
  logic              s1_vld, s1_prot, s1_corr, s1_diag;
  logic [AW-1:0]     s1_addr;

  assign req_ready = !init_busy && !s1_vld && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign host_wr   = accept && req_write;
  assign rd_en     = accept && !req_write;
  assign diag_wr   = diag_en && !prot_en;

  // ---------------- write path ----------------
  logic [DATA_W-1:0] mem_wdata;
  logic [CW-1:0]     gen_chk, mem_wchk;
  logic [AW-1:0]     mem_waddr;
  logic              mem_we_d, mem_we_c;

  assign mem_wdata = init_busy ? '0 : req_wdata;
  assign mem_waddr = init_busy ? init_idx : req_addr;

  ecc_encoder #(.DW(DATA_W), .PW(PW)) u_enc (
    .data (mem_wdata),
    .chk  (gen_chk)
  );

  assign mem_we_d = init_busy || (host_wr && (!diag_wr || req_wmask[0]));
  assign mem_we_c = init_busy ? prot_en
                              : (host_wr && (prot_en || (diag_wr && req_wmask[1])));
  assign mem_wchk = (host_wr && diag_wr) ? req_wchk : gen_chk;

  // ---------------- storage ----------------
  logic [DATA_W-1:0] rd_data;
  logic [CW-1:0]     rd_chk;

  msg_mem #(.DEPTH(NUM_OBJ), .DW(DATA_W), .CW(CW)) u_mem (
    .clk        (clk),
    .wr_data_en (mem_we_d),
    .wr_chk_en  (mem_we_c),
    .waddr      (mem_waddr),
    .wdata      (mem_wdata),
    .wchk       (mem_wchk),
    .rd_en      (rd_en),
    .raddr      (req_addr),
    .rdata      (rd_data),
    .rchk       (rd_chk)
  );

  // ---------------- initialization sweep ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_busy <= 1'b0;
      init_idx  <= '0;
    end else if (init_busy) begin
      if (init_idx == AW'(NUM_OBJ - 1)) init_busy <= 1'b0;
      init_idx <= init_idx + 1'b1;
    end else if (init_start) begin
      init_busy <= 1'b1;
      init_idx  <= '0;
    end
  end

  // ---------------- stage 1: memory latency ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      s1_prot <= 1'b0;
      s1_corr <= 1'b0;
      s1_diag <= 1'b0;
    end else begin
      s1_vld <= rd_en;
      if (rd_en) begin
        s1_addr <= req_addr;
        s1_prot <= prot_en;
        s1_corr <= !corr_off;
        s1_diag <= diag_en;
      end
    end
  end

  // ---------------- stage 2: decode ----------------
  logic [DATA_W-1:0] fixed;
  logic              dec_single, dec_double;
  logic              set_sec, set_ded, set_per;

  ecc_decoder #(.DW(DATA_W), .PW(PW)) u_dec (
    .data   (rd_data),
    .chk    (rd_chk),
    .fixed  (fixed),
    .single (dec_single),
    .double (dec_double)
  );

  assign set_sec = s1_vld && s1_prot && dec_single;
  assign set_ded = s1_vld && s1_prot && dec_double;
  assign set_per = set_ded || (set_sec && !s1_corr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (s1_vld) begin
        rsp_valid <= 1'b1;
        rsp_data  <= (set_sec && s1_corr) ? fixed : rd_data;
      end
    end
  end

  // ---------------- status ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_single  <= 1'b0;
      err_double  <= 1'b0;
      err_parity  <= 1'b0;
      diag_single <= 1'b0;
      diag_double <= 1'b0;
      sec_obj     <= '0;
      ded_obj     <= '0;
    end else begin
      err_single  <= set_sec || (err_single && !flag_clr[CLR_SINGLE]);
      err_double  <= set_ded || (err_double && !flag_clr[CLR_DOUBLE]);
      err_parity  <= set_per || (err_parity && !flag_clr[CLR_PARITY]);
      diag_single <= (set_sec && s1_diag) || (diag_single && !flag_clr[CLR_DSINGLE]);
      diag_double <= (set_ded && s1_diag) || (diag_double && !flag_clr[CLR_DDOUBLE]);
      if (set_sec) sec_obj <= s1_addr;
      if (set_ded) ded_obj <= s1_addr;
    end
  end

  assign irq = err_parity && irq_en;

  // ---------------- valid bits ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obj_valid <= '0;
    end else if (init_start && !init_busy) begin
      obj_valid <= '0;
    end else begin
      if (host_wr && mem_we_d) obj_valid[req_addr] <= req_wvalid;
      if (set_per)             obj_valid[s1_addr]  <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_msg_store_chk.sv
module ecc_msg_store_chk
  import ecc_msg_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int DATA_W  = 136,
  localparam int AW     = $clog2(NUM_OBJ),
  localparam int PW     = parity_bits(DATA_W),
  localparam int CW     = PW + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_en,
  input logic               init_busy,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               err_double,
  input logic               err_parity,
  input logic               diag_double,
  input logic               irq,
  input logic [NUM_OBJ-1:0] obj_valid
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> ##1 rsp_valid); // R1

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || init_busy) |-> !req_ready); // R11

  AST_DOUBLE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_double) |-> err_parity); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (err_parity && irq_en)); // R10

  AST_DIAG_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diag_double) |-> err_double); // R7

  AST_INIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (obj_valid == '0)); // R8

endmodule

bind ecc_msg_store ecc_msg_store_chk #(.NUM_OBJ(NUM_OBJ), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_ecc_msg_store.sv
module test_ecc_msg_store;
  localparam int NOBJ = 32;
  localparam int DW   = 136;
  localparam int AW   = 5;
  localparam int CW   = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prot_en = 0, corr_off = 0, diag_en = 0, irq_en = 1, init_start = 0;
  logic init_busy, req_ready, rsp_valid;
  logic req_valid = 0, req_write = 0, req_wvalid = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] req_wchk = '0;
  logic [1:0] req_wmask = 2'b00;
  logic [4:0] flag_clr = '0;
  logic [DW-1:0] rsp_data;
  logic err_single, err_double, err_parity, diag_single, diag_double, irq;
  logic [AW-1:0] sec_obj, ded_obj;
  logic [NOBJ-1:0] obj_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_msg_store i_ecc_msg_store (.*);

  task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [CW-1:0] c,
                    input logic [1:0] m, input logic v);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(a);
    req_wdata = d; req_wchk = c; req_wmask = m; req_wvalid = v;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  // Returns after the falling edge at which the response is due.
  task automatic rd(input int a, input string req);
    @(negedge clk);
    chk(req_ready == 1'b1, req, 144'(req_ready), 144'd1);
    req_valid = 1; req_write = 0; req_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1'b0, req, 144'(rsp_valid), 144'd0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1, req, 144'(rsp_valid), 144'd1);
  endtask

  task automatic clr_all();
    @(negedge clk); flag_clr = 5'h1f;
    @(negedge clk); flag_clr = 5'h00;
  endtask

  typedef struct packed { logic [7:0] fa; logic [7:0] fb; logic coff; } vec_t;
  localparam vec_t VECS [7] = '{
    '{8'd255, 8'd255, 1'b0},
    '{8'd5,   8'd255, 1'b0},
    '{8'd135, 8'd255, 1'b1},
    '{8'd0,   8'd77,  1'b0},
    '{8'd40,  8'd41,  1'b1},
    '{8'd100, 8'd255, 1'b0},
    '{8'd64,  8'd255, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R12, R1, R9)
    chk(obj_valid == '0, "R12", 144'(obj_valid), 144'd0);
    chk({rsp_valid, err_single, err_double, err_parity, diag_single, diag_double, irq} == '0,
        "R9", 144'({err_single, err_double, err_parity}), 144'd0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", 144'(req_ready), 144'd1);

    // R8: initialization sweep
    prot_en = 1;
    wr(7, {17{8'h11}}, '0, 2'b00, 1'b1);
    chk(obj_valid[7] == 1'b1, "R12", 144'(obj_valid[7]), 144'd1);
    @(negedge clk); init_start = 1;
    @(negedge clk); init_start = 0;
    begin
      int cyc = 0;
      chk(req_ready == 1'b0, "R8", 144'(req_ready), 144'd0);
      while (init_busy) begin cyc++; @(negedge clk); end
      chk(cyc == NOBJ, "R8", 144'(cyc), 144'(NOBJ));
    end
    chk(obj_valid == '0, "R8", 144'(obj_valid), 144'd0);
    rd(7, "R8");
    chk(rsp_data == '0 && !err_single && !err_double, "R8", 144'(rsp_data), 144'd0);

    // Vector table: R1..R4 with injected data faults
    for (int k = 0; k < 7; k++) begin
      logic [DW-1:0] orig, bad, expd;
      int nf, a;
      bit sec, ded, per;
      string tag;
      a = 4 + k;
      orig = {17{8'(8'h3C + k * 29)}};
      bad = orig;
      nf = 0;
      if (VECS[k].fa != 8'd255) begin bad[VECS[k].fa] = ~bad[VECS[k].fa]; nf++; end
      if (VECS[k].fb != 8'd255) begin bad[VECS[k].fb] = ~bad[VECS[k].fb]; nf++; end
      sec = (nf == 1); ded = (nf == 2);
      per = ded || (sec && VECS[k].coff);
      expd = (sec && !VECS[k].coff) ? orig : bad;
      tag = (nf == 0) ? "R1" : ded ? "R4" : VECS[k].coff ? "R3" : "R2";
      clr_all();
      prot_en = 1; diag_en = 0; corr_off = VECS[k].coff;
      wr(a, orig, '0, 2'b00, 1'b1);
      prot_en = 0; diag_en = 1;
      wr(a, bad, '0, 2'b01, 1'b1);
      @(negedge clk); prot_en = 1;
      rd(a, tag);
      chk(rsp_data == expd, tag, 144'(rsp_data), 144'(expd));
      chk(err_single == sec && err_double == ded && err_parity == per, tag,
          144'({err_single, err_double, err_parity}), 144'({sec, ded, per}));
      chk(obj_valid[a] == !per, tag, 144'(obj_valid[a]), 144'(!per));
      chk(irq == per, "R10", 144'(irq), 144'(per));
      chk(diag_single == sec && diag_double == ded, "R7",
          144'({diag_single, diag_double}), 144'({sec, ded}));
      if (sec) chk(sec_obj == AW'(a), tag, 144'(sec_obj), 144'(a));
      if (ded) chk(ded_obj == AW'(a), tag, 144'(ded_obj), 144'(a));
      diag_en = 0; corr_off = 0;
    end

    // R5: faults planted in the check word of a zero object
    clr_all();
    prot_en = 1;
    wr(1, '0, '0, 2'b00, 1'b1);
    prot_en = 0; diag_en = 1;
    wr(1, '0, 9'h100, 2'b10, 1'b1);
    @(negedge clk); prot_en = 1; diag_en = 0;
    rd(1, "R5");
    chk(rsp_data == '0 && err_single && !err_parity, "R5",
        144'({err_single, err_parity}), 144'(2'b10));
    chk(obj_valid[1] == 1'b1 && sec_obj == 5'd1, "R5", 144'(sec_obj), 144'd1);
    chk(diag_single == 1'b0, "R7", 144'(diag_single), 144'd0);
    clr_all();
    prot_en = 0; diag_en = 1;
    wr(1, '0, 9'h003, 2'b10, 1'b1);
    @(negedge clk); prot_en = 1; diag_en = 0;
    rd(1, "R5");
    chk(err_double && err_parity && !err_single, "R5",
        144'({err_single, err_double, err_parity}), 144'(3'b011));
    chk(ded_obj == 5'd1 && obj_valid[1] == 1'b0, "R5", 144'(ded_obj), 144'd1);

    // R10: interrupt gating (parity flag still set)
    @(negedge clk); irq_en = 0;
    #1 chk(irq == 1'b0, "R10", 144'(irq), 144'd0);
    irq_en = 1;
    #1 chk(irq == 1'b1, "R10", 144'(irq), 144'd1);

    // R9: selective clear, sticky across clean reads
    @(negedge clk); flag_clr = 5'b00010;
    @(negedge clk); flag_clr = 5'b00000;
    chk(!err_double && err_parity, "R9", 144'({err_double, err_parity}), 144'(2'b01));
    rd(4, "R9");
    chk(err_parity == 1'b1, "R9", 144'(err_parity), 144'd1);
    clr_all();
    chk(!err_parity && !err_single, "R9", 144'({err_single, err_parity}), 144'd0);

    // R6: protection off - no check, check word kept
    prot_en = 1;
    wr(2, {17{8'h5A}}, '0, 2'b00, 1'b1);
    prot_en = 0;
    wr(2, {17{8'h5A}} ^ (136'd1 << 9), '0, 2'b10, 1'b1);
    rd(2, "R6");
    chk(rsp_data == ({17{8'h5A}} ^ (136'd1 << 9)) && !err_single && !err_double, "R6",
        144'(rsp_data), 144'({17{8'h5A}} ^ (136'd1 << 9)));
    @(negedge clk); prot_en = 1;
    rd(2, "R6");
    chk(rsp_data == {17{8'h5A}} && err_single, "R6", 144'(rsp_data), 144'({17{8'h5A}}));
    clr_all();

    // R11: response back-pressure
    rsp_ready = 0;
    rd(3, "R11");
    begin
      logic [DW-1:0] held;
      held = rsp_data;
      repeat (3) @(negedge clk);
      chk(rsp_valid && rsp_data == held, "R11", 144'(rsp_data), 144'(held));
      chk(req_ready == 1'b0, "R11", 144'(req_ready), 144'd0);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11", 144'({rsp_valid, req_ready}), 144'(2'b01));

    // R12: valid bit follows write
    wr(9, {17{8'h77}}, '0, 2'b00, 1'b0);
    chk(obj_valid[9] == 1'b0, "R12", 144'(obj_valid[9]), 144'd0);
    wr(9, {17{8'h77}}, '0, 2'b00, 1'b1);
    chk(obj_valid[9] == 1'b1, "R12", 144'(obj_valid[9]), 144'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule